// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic stage of an accumulator machine. Each cycle in which an operation is presented, it combines the accumulator value with a second byte under the selected operation. The second byte may come from a register, from memory or from an immediate field. The block registers the new accumulator value together with a write strobe, and it updates an internal five-flag register: sign, zero, auxiliary (nibble) carry, even parity and carry. The flags are presented as one packed status byte.

The surrounding core supplies the accumulator and the operand, and it writes the returned value back whenever the strobe is high. The incoming carry for carry-using operations, rotates through carry and decimal adjust is always the carry held in the block's own flag register. The operation set covers add and subtract, each with and without carry or borrow, compare, the three bitwise operations, increment and decrement, four accumulator rotations, complement, carry complement, carry set, and decimal adjust after BCD addition.

Top module: `accum_alu`

## Requirements
- R1: While `rstN` is low, and after it rises, `accOut` is 0x00, `accWe` is 0 and `flags` is 0x02, until the first accepted operation.
- R2: An operation is accepted on a rising clock edge with `opValid` high. Its results appear on `accOut`, `accWe` and `flags` after that edge. `accWe` is high for one cycle only when the operation writes the accumulator. The opcodes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 complement, 15 complement carry, 16 set carry, 17 decimal adjust. Codes 18 to 31, and cycles without `opValid`, leave `accWe` low and the flags unchanged.
- R3: `flags` is packed as {S, Z, 0, AC, 0, P, 1, CY} from bit 7 to bit 0. Whenever an operation updates them, Z is 1 exactly when the 8-bit result is 0x00, S equals result bit 7, and P is 1 when the result holds an even number of one bits.
- R4: Add (0) and add with carry (1) write A + B (+ CY for opcode 1) modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R5: Subtract (2) and subtract with borrow (3) write A - B (- CY for opcode 3) modulo 256. CY is 1 when B (plus the borrow) exceeds A as unsigned values. AC is the carry out of bit 3 of the sum A[3:0] + ~B[3:0] + (1 - borrow in).
- R6: Compare (7) sets S, Z, AC, P and CY exactly as subtract (2) would, and does not write the accumulator.
- R7: AND (4), XOR (5) and OR (6) write the bitwise result and clear both CY and AC.
- R8: Increment (8) and decrement (9) write A+1 and A-1 modulo 256 and update S, Z, P and AC, leaving CY unchanged. AC is 1 for increment when A[3:0] is 0xF, and for decrement when A[3:0] is not 0.
- R9: Rotate left (10) moves bit 7 into bit 0 and into CY. Rotate right (11) moves bit 0 into bit 7 and into CY. Rotate left through carry (12) shifts the old CY into bit 0 and bit 7 into CY. Rotate right through carry (13) shifts the old CY into bit 7 and bit 0 into CY. Rotates change no flag other than CY.
- R10: Complement (14) writes ~A and changes no flag. Complement carry (15) inverts CY only, and set carry (16) sets CY only. Neither of the last two writes the accumulator.
- R11: Decimal adjust (17) adds 0x06 when A[3:0] > 9 or AC is 1. It adds 0x60 when A > 0x99 or CY is 1, and in that case it sets CY; otherwise CY is cleared. AC becomes the carry out of bit 3 of that addition, and S, Z and P follow the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Execute the operation on `opCode` at this edge |
| opCode | input | 5 | Operation select, encoding in R2 |
| accIn | input | 8 | Current accumulator value |
| operand | input | 8 | Second operand byte |
| accOut | output | 8 | Registered new accumulator value |
| accWe | output | 1 | One-cycle strobe: write `accOut` back to the accumulator |
| flags | output | 8 | Packed status byte, layout in R3 |

## Verification
The flag register is the block's only long-lived state. A wrong carry or auxiliary carry is visible on `flags` one cycle after the operation that produced it. It also spreads into the following carry-using add, subtract, through-carry rotate or decimal adjust, and then shows up in `accOut` itself. The bench therefore runs long random operation streams in which the carry threads from one operation to the next, against a model that keeps its own flag state. A stale flag is caught at the first operation that reads it. A missing write strobe, or a spurious one, shows on `accWe` in the cycle after the opcode.

// File: rtl/alu_pkg.sv
package alu_pkg;

  parameter int DATA_W = 8;
  parameter int NIB_W  = 4;
  parameter int OP_W   = 5;

  localparam logic [DATA_W-1:0] BCD_LO_FIX = 8'h06;
  localparam logic [DATA_W-1:0] BCD_HI_FIX = 8'h60;
  localparam logic [NIB_W-1:0]  BCD_MAX    = 4'd9;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16, OP_DAA = 5'd17
  } aluOp_e;

  typedef enum logic [2:0] {
    U_NONE, U_ADD, U_LOGIC, U_ROT, U_CMA, U_DAA
  } unit_e;

  typedef enum logic [1:0] { ROT_LC, ROT_RC, ROT_LT, ROT_RT } rot_e;

  typedef enum logic [1:0] { CY_KEEP, CY_UNIT, CY_FLIP, CY_SET } cyMode_e;

  typedef enum logic [1:0] { LG_AND, LG_XOR, LG_OR } logic_e;

  typedef struct packed {
    logic    fire;
    unit_e   unit;
    logic    constOne;
    logic    invertB;
    logic    useCarry;
    logic_e  logicOp;
    rot_e    rot;
    cyMode_e cyMode;
    logic    updAc;
    logic    updZsp;
    logic    wrAcc;
  } strobe_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output strobe_t         str
);

  always_comb begin
    str          = '0;
    str.unit     = U_NONE;
    str.logicOp  = LG_AND;
    str.rot      = ROT_LC;
    str.cyMode   = CY_KEEP;
    str.fire     = opValid;
    if (opValid) begin
      case (opCode)
        OP_ADD, OP_ADC: begin
          str.unit     = U_ADD;
          str.useCarry = (opCode == OP_ADC);
          str.cyMode   = CY_UNIT;
          str.updAc    = 1'b1;
          str.updZsp   = 1'b1;
          str.wrAcc    = 1'b1;
        end
        OP_SUB, OP_SBB, OP_CMP: begin
          str.unit     = U_ADD;
          str.invertB  = 1'b1;
          str.useCarry = (opCode == OP_SBB);
          str.cyMode   = CY_UNIT;
          str.updAc    = 1'b1;
          str.updZsp   = 1'b1;
          str.wrAcc    = (opCode != OP_CMP);
        end
        OP_AND, OP_XOR, OP_OR: begin
          str.unit    = U_LOGIC;
          str.logicOp = (opCode == OP_AND) ? LG_AND :
                        (opCode == OP_XOR) ? LG_XOR : LG_OR;
          str.cyMode  = CY_UNIT;
          str.updAc   = 1'b1;
          str.updZsp  = 1'b1;
          str.wrAcc   = 1'b1;
        end
        OP_INC, OP_DEC: begin
          str.unit     = U_ADD;
          str.constOne = 1'b1;
          str.invertB  = (opCode == OP_DEC);
          str.updAc    = 1'b1;
          str.updZsp   = 1'b1;
          str.wrAcc    = 1'b1;
        end
        OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
          str.unit   = U_ROT;
          str.rot    = (opCode == OP_RLC) ? ROT_LC :
                       (opCode == OP_RRC) ? ROT_RC :
                       (opCode == OP_RAL) ? ROT_LT : ROT_RT;
          str.cyMode = CY_UNIT;
          str.wrAcc  = 1'b1;
        end
        OP_CMA: begin
          str.unit  = U_CMA;
          str.wrAcc = 1'b1;
        end
        OP_CMC: str.cyMode = CY_FLIP;
        OP_STC: str.cyMode = CY_SET;
        OP_DAA: begin
          str.unit   = U_DAA;
          str.cyMode = CY_UNIT;
          str.updAc  = 1'b1;
          str.updZsp = 1'b1;
          str.wrAcc  = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic              accWe,
  output logic [DATA_W-1:0] flags
);

  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] accQ;
  logic              weQ, cyQ, zQ, sQ, pQ, acQ;

  // adder path shared by add, subtract, compare, increment, decrement
  logic [DATA_W-1:0] bSrc, bEff;
  logic              cinRaw, cin;
  logic [DATA_W:0]   sumWide;
  logic [NIB_W:0]    nibSum;
  logic              addCy, addAc;

  always_comb begin
    bSrc    = str.constOne ? DATA_W'(1) : operand;
    bEff    = str.invertB ? ~bSrc : bSrc;
    cinRaw  = str.useCarry & cyQ;
    cin     = str.invertB ? ~cinRaw : cinRaw;
    sumWide = {1'b0, accIn} + {1'b0, bEff} + {{DATA_W{1'b0}}, cin};
    nibSum  = {1'b0, accIn[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    addAc   = nibSum[NIB_W];
    addCy   = str.invertB ? ~sumWide[DATA_W] : sumWide[DATA_W];
  end

  // bitwise path
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (str.logicOp)
      LG_AND:  logicRes = accIn & operand;
      LG_XOR:  logicRes = accIn ^ operand;
      default: logicRes = accIn | operand;
    endcase
  end

  // rotate path
  logic [DATA_W-1:0] rotRes;
  logic              rotCy;
  always_comb begin
    case (str.rot)
      ROT_LC: begin rotRes = {accIn[TOP-1:0], accIn[TOP]}; rotCy = accIn[TOP]; end
      ROT_RC: begin rotRes = {accIn[0], accIn[TOP:1]};     rotCy = accIn[0];   end
      ROT_LT: begin rotRes = {accIn[TOP-1:0], cyQ};        rotCy = accIn[TOP]; end
      default: begin rotRes = {cyQ, accIn[TOP:1]};         rotCy = accIn[0];   end
    endcase
  end

  // decimal adjust path
  logic              fixLo, fixHi;
  logic [DATA_W-1:0] daaAdj, daaRes;
  logic [NIB_W:0]    daaNib;
  always_comb begin
    fixLo  = (accIn[NIB_W-1:0] > BCD_MAX) | acQ;
    fixHi  = (accIn[TOP:NIB_W] > BCD_MAX) |
             ((accIn[TOP:NIB_W] == BCD_MAX) & (accIn[NIB_W-1:0] > BCD_MAX)) | cyQ;
    daaAdj = (fixLo ? BCD_LO_FIX : '0) | (fixHi ? BCD_HI_FIX : '0);
    daaRes = accIn + daaAdj;
    daaNib = {1'b0, accIn[NIB_W-1:0]} + {1'b0, daaAdj[NIB_W-1:0]};
  end

  // result and flag selection
  logic [DATA_W-1:0] resV;
  logic              unitCy, unitAc;
  always_comb begin
    resV   = accIn;
    unitCy = cyQ;
    unitAc = acQ;
    case (str.unit)
      U_ADD:   begin resV = sumWide[DATA_W-1:0]; unitCy = addCy; unitAc = addAc; end
      U_LOGIC: begin resV = logicRes; unitCy = 1'b0; unitAc = 1'b0; end
      U_ROT:   begin resV = rotRes; unitCy = rotCy; end
      U_CMA:   resV = ~accIn;
      U_DAA:   begin resV = daaRes; unitCy = fixHi; unitAc = daaNib[NIB_W]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      weQ  <= 1'b0;
      cyQ  <= 1'b0;
      zQ   <= 1'b0;
      sQ   <= 1'b0;
      pQ   <= 1'b0;
      acQ  <= 1'b0;
    end else begin
      weQ <= str.fire & str.wrAcc;
      if (str.fire) begin
        if (str.wrAcc) accQ <= resV;
        if (str.updZsp) begin
          zQ <= (resV == '0);
          sQ <= resV[TOP];
          pQ <= ~^resV;
        end
        if (str.updAc) acQ <= unitAc;
        case (str.cyMode)
          CY_UNIT: cyQ <= unitCy;
          CY_FLIP: cyQ <= ~cyQ;
          CY_SET:  cyQ <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign accOut = accQ;
  assign accWe  = weQ;
  assign flags  = {sQ, zQ, 1'b0, acQ, 1'b0, pQ, 1'b1, cyQ};

  AST_ZSP_FOLLOW_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (str.fire && str.updZsp && str.wrAcc) |=>
      (zQ == (accQ == '0)) && (sQ == accQ[TOP]) && (pQ == ~^accQ)); // R3

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !str.fire |=> !weQ && $stable(cyQ) && $stable(zQ) && $stable(sQ)
                 && $stable(pQ) && $stable(acQ) && $stable(accQ)); // R2

  AST_ROTATE_ONLY_CY: assert property (@(posedge clk) disable iff (!rstN)
    (str.fire && str.unit == U_ROT) |=>
      $stable(zQ) && $stable(sQ) && $stable(pQ) && $stable(acQ)); // R9

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic              accWe,
  output logic [DATA_W-1:0] flags
);

  strobe_t str;

  accum_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .str     (str)
  );

  accum_alu_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .accIn   (accIn),
    .operand (operand),
    .accOut  (accOut),
    .accWe   (accWe),
    .flags   (flags)
  );

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMP) |=> !accWe); // R6

  AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_AND || opCode == OP_XOR || opCode == OP_OR))
      |=> (flags[0] == 1'b0) && (flags[4] == 1'b0)); // R7

  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_INC || opCode == OP_DEC)) |=> $stable(flags[0])); // R8

  AST_STC_SETS_CY: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STC) |=> flags[0] && !accWe); // R10

  AST_CMA_INVERTS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CMA) |=> accWe && (accOut == ~$past(accIn)) && $stable(flags)); // R10

  AST_WE_PULSE_NEEDS_OP: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !accWe); // R2

endmodule

// File: tb/accum_alu_test.sv
`timescale 1ns/1ps
module accum_alu_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] operand = '0;
  logic [7:0] accOut;
  logic       accWe;
  logic [7:0] flags;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expFlags = 8'h02;

  always #10 clk = ~clk;

  accum_alu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operand(operand), .accOut(accOut), .accWe(accWe), .flags(flags)
  );

  function automatic logic [7:0] packFlags(int s, int z, int ac, int p, int cy);
    return {s[0], z[0], 1'b0, ac[0], 1'b0, p[0], 1'b1, cy[0]};
  endfunction

  function automatic int evenOnes(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0, 1: return "R4";
      2, 3: return "R5";
      7: return "R6";
      4, 5, 6: return "R7";
      8, 9: return "R8";
      10, 11, 12, 13: return "R9";
      14, 15, 16: return "R10";
      17: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic report(input bit ok, input string tag, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(input int op, input int a, input int b, input string tag);
    int cy, ac, s, z, p, r, w, d, adj;
    bit we, szp;
    logic [7:0] nf;
    cy = expFlags[0]; ac = expFlags[4];
    s = expFlags[7]; z = expFlags[6]; p = expFlags[2];
    r = a; we = 1; szp = 1;
    case (op)
      0, 1: begin
        w = (op == 1) ? cy : 0;
        r = a + b + w;
        ac = (((a & 15) + (b & 15) + w) > 15) ? 1 : 0;
        cy = (r > 255) ? 1 : 0;
      end
      2, 3, 7: begin
        w = (op == 3) ? cy : 0;
        d = a - b - w;
        ac = (((a & 15) + ((~b) & 15) + (1 - w)) > 15) ? 1 : 0;
        cy = (d < 0) ? 1 : 0;
        r = d & 255;
        if (op == 7) we = 0;
      end
      4: begin r = a & b; cy = 0; ac = 0; end
      5: begin r = a ^ b; cy = 0; ac = 0; end
      6: begin r = a | b; cy = 0; ac = 0; end
      8: begin r = a + 1; ac = ((a & 15) == 15) ? 1 : 0; end
      9: begin r = (a + 255) & 255; ac = ((a & 15) != 0) ? 1 : 0; end
      10: begin r = ((a << 1) | (a >> 7)); cy = (a >> 7) & 1; szp = 0; end
      11: begin r = ((a >> 1) | ((a & 1) << 7)); cy = a & 1; szp = 0; end
      12: begin r = ((a << 1) | cy); cy = (a >> 7) & 1; szp = 0; end
      13: begin r = ((a >> 1) | (cy << 7)); cy = a & 1; szp = 0; end
      14: begin r = (~a) & 255; szp = 0; end
      15: begin cy = 1 - cy; we = 0; szp = 0; end
      16: begin cy = 1; we = 0; szp = 0; end
      17: begin
        adj = 0;
        if ((a & 15) > 9 || ac == 1) adj += 6;
        if (a > 'h99 || cy == 1) begin adj += 'h60; cy = 1; end else cy = 0;
        ac = (((a & 15) + (adj & 15)) > 15) ? 1 : 0;
        r = a + adj;
      end
      default: begin we = 0; szp = 0; end
    endcase
    r = r & 255;
    if (szp) begin
      z = (r == 0) ? 1 : 0;
      s = (r >> 7) & 1;
      p = evenOnes(r);
    end
    nf = packFlags(s, z, ac, p, cy);
    opValid = 1'b1; opCode = op[4:0]; accIn = a[7:0]; operand = b[7:0];
    @(negedge clk);
    report((accWe == we) && (flags == nf) && (!we || accOut == r[7:0]), tag,
           $sformatf("op=%0d a=%h b=%h {we,flags,acc}", op, a, b),
           {23'd0, accWe, flags, accOut}, {23'd0, we, nf, r[7:0]});
    expFlags = nf;
  endtask

  task automatic idle();
    opValid = 1'b0; opCode = 5'd0; accIn = 8'hA5; operand = 8'h5A;
    @(negedge clk);
    report(!accWe && flags == expFlags, "R2", "idle {we,flags}",
           {23'd0, accWe, flags, 8'd0}, {23'd0, 1'b0, expFlags, 8'd0});
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7919));
    repeat (3) @(negedge clk);
    report(accOut == 8'h00 && !accWe && flags == 8'h02, "R1", "in reset {we,flags,acc}",
           {23'd0, accWe, flags, accOut}, {23'd0, 1'b0, 8'h02, 8'h00});
    rstN = 1'b1;
    @(negedge clk);
    report(accOut == 8'h00 && !accWe && flags == 8'h02, "R1", "after reset {we,flags,acc}",
           {23'd0, accWe, flags, accOut}, {23'd0, 1'b0, 8'h02, 8'h00});

    // directed corners
    doOp(0, 'hFF, 'h01, "R4");   // wrap to zero, CY and AC set
    doOp(1, 'h10, 'h20, "R4");   // carry folded in
    doOp(0, 'h7F, 'h01, "R3");   // sign and parity
    doOp(2, 'h10, 'h01, "R5");   // nibble borrow
    doOp(3, 'h00, 'h00, "R5");   // borrow chained into zero
    doOp(7, 'h42, 'h42, "R6");   // equal compare
    doOp(7, 'h01, 'h02, "R6");   // compare below
    doOp(4, 'hF0, 'h3C, "R7");
    doOp(16, 0, 0, "R10");
    doOp(8, 'hFF, 0, "R8");      // keeps CY=1
    doOp(9, 'h00, 0, "R8");
    doOp(13, 'h01, 0, "R9");
    doOp(12, 'h80, 0, "R9");
    doOp(10, 'h81, 0, "R9");
    doOp(11, 'h02, 0, "R9");
    doOp(15, 0, 0, "R10");
    doOp(14, 'h5A, 0, "R10");
    doOp(0, 'h38, 'h45, "R11");
    doOp(17, 'h7D, 0, "R11");    // 38+45 -> 83
    doOp(0, 'h99, 'h01, "R11");
    doOp(17, 'h9A, 0, "R11");    // 99+1 -> 00 carry
    doOp(25, 'h33, 'h44, "R2");
    idle();

    for (int i = 0; i < 4000; i++) begin
      int op, a, b;
      if ($urandom_range(0, 15) == 0) idle();
      op = $urandom_range(0, 19);
      a  = $urandom_range(0, 255);
      b  = $urandom_range(0, 255);
      doOp(op, a, b, tagOf(op));
    end

    opValid = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule